// File: doc/BRIEF.md
# Serial-to-NAND Bridge

This block lets a host that has only a serial port drive an 8-bit parallel NAND flash. The host selects the bridge with an active-low select and shifts an opcode byte in, most significant bit first, sampled on rising serial clock edges (clock idles low). The opcode then sets how the rest of the frame is used. A write frame puts bytes onto the flash bus with write strobes. A configuration frame loads a register that drives the flash chip-enable, command-latch and address-latch lines, plus a fan output and four LED outputs. A normal read frame and a fast read frame pull bytes off the flash with read strobes and return them on the serial output.

All serial inputs are brought into the system clock domain through synchronizers and sampled there. The serial clock must therefore be slow enough that every half period covers the synchronizer delay and one complete flash strobe cycle. The flash ready line is passed straight back to the host, so the host can poll it between frames.

Top module: `spinb_bridge`

## Requirements
- R1: After reset the outputs are: chip enable high (inactive), all four active-low LED lines high, command latch, address latch and fan low, both strobes high, data bus not driven, serial output low.
- R2: Opcode 0x09 loads the first byte after the opcode into the configuration register. The bits map as: bit 7 to chip enable (active low), bit 6 to command latch, bit 5 to address latch, bit 4 to fan, and bits 3..0 to active-low LED lines 4..1. Further bytes in the same frame leave the register unchanged.
- R3: The opcode and all single-line bytes are taken on the primary data line, most significant bit first, one bit per rising serial clock.
- R4: Opcode 0x08 takes its bytes two bits per clock. The pairs arrive in the order 7/6, 5/4, 3/2, 1/0, with the higher bit of each pair on the primary line. Every byte of the frame except the last is written to the flash, in order. The last byte is a trailing byte and is discarded.
- R5: A flash write drives the bus at least one clock before the write strobe falls. It holds the write strobe low for STROBE_CLKS clocks (at least two) with the bus stable, and keeps driving the bus for one clock after the strobe rises.
- R6: Opcode 0x0A is followed by one dummy byte. Each later byte slot then returns the next flash byte on the serial output, most significant bit first. The first bit is valid before the slot's first rising edge, and the output changes after falling edges.
- R7: Opcode 0x0B works like R6 but is followed by four dummy bytes. No flash read starts before the fourth dummy byte is complete.
- R8: A read holds the read strobe low for STROBE_CLKS clocks with the bus not driven. The two strobes are never low together. A read does not start while flash ready is low; it waits until ready is high.
- R9: The host ready output equals the flash ready input at all times.
- R10: Raising the select aborts the frame. A partial byte is discarded and the next frame starts with an opcode.
- R11: An opcode other than 0x08 to 0x0B makes the rest of its frame have no effect: no flash cycle takes place and the configuration does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Primary serial data in |
| spi_mosi2 | input | 1 | Second data line, used only by the write opcode |
| spi_miso | output | 1 | Serial data out |
| nand_dq_o | output | 8 | Flash bus data out |
| nand_dq_oe | output | 1 | Flash bus output enable |
| nand_dq_i | input | 8 | Flash bus data in |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_rdy | input | 1 | Flash ready/busy, high when ready |
| host_rdy | output | 1 | Ready returned to the host |
| nand_ce_n | output | 1 | Active-low chip enable from configuration |
| nand_cle | output | 1 | Command latch enable from configuration |
| nand_ale | output | 1 | Address latch enable from configuration |
| fan_on | output | 1 | Fan control from configuration |
| led_n | output | 4 | Active-low LED lines 4..1 |

## Verification
The bench builds the bridge with its default parameters: two synchronizer stages, a two-clock strobe, one dummy byte for the normal read and four for the fast read. It runs the serial clock at ten system clocks per half period. That rate leaves room for a full read strobe between byte slots, and it lets a bench-side flash model see every strobe edge. With these settings the bench can check the dual-line bit order, the dropped trailing write byte, the dummy-byte counts, and reads held back by a low ready line, all within a few thousand clocks.

// File: rtl/spinb_pkg.sv
package spinb_pkg;

  localparam logic [7:0] OP_WRITE     = 8'h08;
  localparam logic [7:0] OP_CONFIG    = 8'h09;
  localparam logic [7:0] OP_READ      = 8'h0A;
  localparam logic [7:0] OP_READ_FAST = 8'h0B;

  typedef struct packed {
    logic       ce_n;
    logic       cle;
    logic       ale;
    logic       fan;
    logic [3:0] led_n;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0, fan: 1'b0, led_n: 4'hF};

  typedef enum logic [2:0] {
    FR_OPCODE, FR_CONFIG, FR_WRITE, FR_DUMMY, FR_READ, FR_SKIP
  } frame_state_t;

  typedef enum logic [1:0] {
    NC_IDLE, NC_SETUP, NC_STROBE, NC_HOLD
  } cycle_state_t;

endpackage

// File: rtl/spinb_sync.sv
module spinb_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spinb_frame.sv
module spinb_frame
  import spinb_pkg::*;
#(
  parameter int FAST_DUMMY = 4,
  parameter int SLOW_DUMMY = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       cs_n_s,
  input  logic       mosi_s,
  input  logic       mosi2_s,
  output logic       miso,
  output logic       cfg_we,
  output logic [7:0] cfg_data,
  output logic       wr_req,
  output logic [7:0] wr_data,
  output logic       rd_req,
  input  logic       rd_done,
  input  logic [7:0] rd_data
);

  localparam int MAX_DUMMY = (FAST_DUMMY > SLOW_DUMMY) ? FAST_DUMMY : SLOW_DUMMY;
  localparam int DW        = $clog2(MAX_DUMMY + 1);

  frame_state_t state_q, state_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [7:0]    rx_q, rx_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    pend_q, pend_d;
  logic          have_pend_q, have_pend_d;
  logic [DW-1:0] dummy_q, dummy_d;
  logic          sck_prev_q;

  logic       sck_rise, sck_fall, sel, dual, last_bit, byte_done;
  logic [7:0] rx_shift;

  always_comb begin
    sck_rise  = sck_s & ~sck_prev_q;
    sck_fall  = ~sck_s & sck_prev_q;
    sel       = ~cs_n_s;
    dual      = (state_q == FR_WRITE);
    rx_shift  = dual ? {rx_q[5:0], mosi_s, mosi2_s} : {rx_q[6:0], mosi_s};
    last_bit  = dual ? (cnt_q == 3'd6) : (cnt_q == 3'd7);
    byte_done = sel & sck_rise & last_bit;

    state_d     = state_q;
    cnt_d       = cnt_q;
    rx_d        = rx_q;
    tx_d        = tx_q;
    pend_d      = pend_q;
    have_pend_d = have_pend_q;
    dummy_d     = dummy_q;
    cfg_we      = 1'b0;
    wr_req      = 1'b0;
    rd_req      = 1'b0;

    if (!sel) begin
      state_d     = FR_OPCODE;
      cnt_d       = 3'd0;
      have_pend_d = 1'b0;
    end else begin
      if (sck_rise) begin
        rx_d  = rx_shift;
        cnt_d = cnt_q + (dual ? 3'd2 : 3'd1);
      end
      if (sck_fall && (state_q == FR_READ) && (cnt_q != 3'd0)) begin
        tx_d = {tx_q[6:0], 1'b0};
      end
      if (byte_done) begin
        case (state_q)
          FR_OPCODE: begin
            case (rx_shift)
              OP_WRITE:     state_d = FR_WRITE;
              OP_CONFIG:    state_d = FR_CONFIG;
              OP_READ: begin
                state_d = FR_DUMMY;
                dummy_d = DW'(SLOW_DUMMY - 1);
              end
              OP_READ_FAST: begin
                state_d = FR_DUMMY;
                dummy_d = DW'(FAST_DUMMY - 1);
              end
              default:      state_d = FR_SKIP;
            endcase
          end
          FR_CONFIG: begin
            cfg_we  = 1'b1;
            state_d = FR_SKIP;
          end
          FR_WRITE: begin
            wr_req      = have_pend_q;
            pend_d      = rx_shift;
            have_pend_d = 1'b1;
          end
          FR_DUMMY: begin
            if (dummy_q == '0) begin
              rd_req  = 1'b1;
              state_d = FR_READ;
            end else begin
              dummy_d = dummy_q - 1'b1;
            end
          end
          FR_READ:  rd_req = 1'b1;
          default:  ;
        endcase
      end
    end

    if (rd_done) tx_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= FR_OPCODE;
      cnt_q       <= 3'd0;
      rx_q        <= 8'h00;
      tx_q        <= 8'h00;
      pend_q      <= 8'h00;
      have_pend_q <= 1'b0;
      dummy_q     <= '0;
      sck_prev_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      rx_q        <= rx_d;
      tx_q        <= tx_d;
      pend_q      <= pend_d;
      have_pend_q <= have_pend_d;
      dummy_q     <= dummy_d;
      sck_prev_q  <= sck_s;
    end
  end

  assign cfg_data = rx_shift;
  assign wr_data  = pend_q;
  assign miso     = (state_q == FR_READ) ? tx_q[7] : 1'b0;

endmodule

// File: rtl/spinb_nand_cycle.sv
module spinb_nand_cycle
  import spinb_pkg::*;
#(
  parameter int STROBE_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_req,
  input  logic [7:0] wr_data,
  input  logic       rd_req,
  input  logic       nand_rdy,
  input  logic [7:0] nand_dq_i,
  output logic [7:0] nand_dq_o,
  output logic       nand_dq_oe,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic       rd_done,
  output logic [7:0] rd_data
);

  localparam int CW = $clog2(STROBE_CLKS + 1);

  cycle_state_t  state_q, state_d;
  logic          is_rd_q, is_rd_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    dout_q, dout_d;
  logic [7:0]    rdata_q, rdata_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    is_rd_d = is_rd_q;
    pend_d  = pend_q | rd_req;
    cnt_d   = cnt_q;
    dout_d  = dout_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;

    case (state_q)
      NC_IDLE: begin
        if (wr_req) begin
          state_d = NC_SETUP;
          is_rd_d = 1'b0;
          dout_d  = wr_data;
        end else if ((pend_q || rd_req) && nand_rdy) begin
          state_d = NC_STROBE;
          is_rd_d = 1'b1;
          cnt_d   = CW'(STROBE_CLKS - 1);
          pend_d  = 1'b0;
        end
      end
      NC_SETUP: begin
        state_d = NC_STROBE;
        cnt_d   = CW'(STROBE_CLKS - 1);
      end
      NC_STROBE: begin
        if (cnt_q == '0) begin
          state_d = NC_HOLD;
          if (is_rd_q) begin
            rdata_d = nand_dq_i;
            done_d  = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = NC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NC_IDLE;
      is_rd_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      dout_q  <= 8'h00;
      rdata_q <= 8'h00;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      is_rd_q <= is_rd_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      dout_q  <= dout_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
    end
  end

  assign nand_dq_o  = dout_q;
  assign nand_dq_oe = (state_q != NC_IDLE) && !is_rd_q;
  assign nand_we_n  = !((state_q == NC_STROBE) && !is_rd_q);
  assign nand_re_n  = !((state_q == NC_STROBE) && is_rd_q);
  assign rd_done    = done_q;
  assign rd_data    = rdata_q;

endmodule

// File: rtl/spinb_bridge.sv
module spinb_bridge
  import spinb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STROBE_CLKS = 2,
  parameter int FAST_DUMMY  = 4,
  parameter int SLOW_DUMMY  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic       spi_mosi2,
  output logic       spi_miso,
  output logic [7:0] nand_dq_o,
  output logic       nand_dq_oe,
  input  logic [7:0] nand_dq_i,
  output logic       nand_we_n,
  output logic       nand_re_n,
  input  logic       nand_rdy,
  output logic       host_rdy,
  output logic       nand_ce_n,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       fan_on,
  output logic [3:0] led_n
);

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [3:0] pins_s;
  spinb_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RST_VAL(4'b1000)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({spi_cs_n, spi_sck, spi_mosi, spi_mosi2}),
    .q     (pins_s)
  );

  logic       cfg_we, wr_req, rd_req, rd_done;
  logic [7:0] cfg_data, wr_data, rd_data;

  spinb_frame #(.FAST_DUMMY(FAST_DUMMY), .SLOW_DUMMY(SLOW_DUMMY)) u_frame (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sck_s    (pins_s[2]),
    .cs_n_s   (pins_s[3]),
    .mosi_s   (pins_s[1]),
    .mosi2_s  (pins_s[0]),
    .miso     (spi_miso),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data),
    .wr_req   (wr_req),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_done  (rd_done),
    .rd_data  (rd_data)
  );

  spinb_nand_cycle #(.STROBE_CLKS(STROBE_CLKS)) u_cycle (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_req     (wr_req),
    .wr_data    (wr_data),
    .rd_req     (rd_req),
    .nand_rdy   (nand_rdy),
    .nand_dq_i  (nand_dq_i),
    .nand_dq_o  (nand_dq_o),
    .nand_dq_oe (nand_dq_oe),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .rd_done    (rd_done),
    .rd_data    (rd_data)
  );

  cfg_t cfg_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  cfg_q <= CFG_RESET;
    else if (cfg_we)  cfg_q <= cfg_t'(cfg_data);
  end

  assign nand_ce_n = cfg_q.ce_n;
  assign nand_cle  = cfg_q.cle;
  assign nand_ale  = cfg_q.ale;
  assign fan_on    = cfg_q.fan;
  assign led_n     = cfg_q.led_n;
  assign host_rdy  = nand_rdy;

endmodule

// File: rtl/spinb_checks.sv
module spinb_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_dq_oe,
  input logic [7:0] nand_dq_o,
  input logic       nand_rdy,
  input logic       host_rdy
);

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_we_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> $past(nand_dq_oe));

  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> ($past(nand_we_n, 2) == 1'b0));

  p_we_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (nand_dq_oe && $stable(nand_dq_o)));

  p_we_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> nand_dq_oe);

  p_re_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_re_n) |-> ($past(nand_re_n, 2) == 1'b0));

  p_re_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |-> $past(nand_rdy));

  p_re_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  p_rdy_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy == nand_rdy);

endmodule

bind spinb_bridge spinb_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe),
  .nand_dq_o  (nand_dq_o),
  .nand_rdy   (nand_rdy),
  .host_rdy   (host_rdy)
);

// File: tb/sim_spinb_bridge.sv
module sim_spinb_bridge;

  localparam int CLK_PERIOD  = 10;
  localparam int HALF        = 10 * CLK_PERIOD;
  localparam int STROBE_CLKS = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_sck, spi_cs_n, spi_mosi, spi_mosi2;
  logic       spi_miso;
  logic [7:0] nand_dq_o, nand_dq_i;
  logic       nand_dq_oe, nand_we_n, nand_re_n, nand_rdy, host_rdy;
  logic       nand_ce_n, nand_cle, nand_ale, fan_on;
  logic [3:0] led_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spinb_bridge #(.STROBE_CLKS(STROBE_CLKS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_mosi2(spi_mosi2),
    .spi_miso(spi_miso),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rdy(nand_rdy), .host_rdy(host_rdy),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .fan_on(fan_on), .led_n(led_n)
  );

  // Behavioural flash model
  logic [7:0] wr_log[$];
  int         rd_idx = 0;
  int         we_low = 0;
  int         re_low = 0;
  logic       prev_we = 1'b1, prev_re = 1'b1, prev_rdy = 1'b1;

  function automatic logic [7:0] rd_pattern(input int i);
    return 8'((i * 29) + 8'h47);
  endfunction

  assign nand_dq_i = rd_pattern(rd_idx);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 ready passthrough", 32'(host_rdy), 32'(nand_rdy));
      chk("R8 strobes exclusive", 32'(nand_we_n | nand_re_n), 32'd1);
      if (!nand_re_n) chk("R8 bus released in read", 32'(nand_dq_oe), 32'd0);
      if (prev_re && !nand_re_n) chk("R8 read waits for ready", 32'(prev_rdy), 32'd1);
      if (!nand_we_n) we_low++;
      if (!nand_re_n) re_low++;
      if (!prev_we && nand_we_n) begin
        chk("R5 write strobe width", 32'(we_low >= STROBE_CLKS), 32'd1);
        chk("R5 write hold", 32'(nand_dq_oe), 32'd1);
        wr_log.push_back(nand_dq_o);
        we_low = 0;
      end
      if (!prev_re && nand_re_n) begin
        chk("R8 read strobe width", 32'(re_low >= STROBE_CLKS), 32'd1);
        rd_idx++;
        re_low = 0;
      end
    end
    prev_we  = nand_we_n;
    prev_re  = nand_re_n;
    prev_rdy = nand_rdy;
  end

  // Serial host tasks
  task automatic spi_clock(input logic b1, input logic b2, output logic got);
    spi_mosi  = b1;
    spi_mosi2 = b2;
    #(HALF);
    got     = spi_miso;
    spi_sck = 1'b1;
    #(HALF);
    spi_sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic g;
      spi_clock(b[i], 1'b0, g);
      r[i] = g;
    end
  endtask

  task automatic send_dual(input logic [7:0] b);
    for (int k = 3; k >= 0; k--) begin
      logic g;
      spi_clock(b[2*k+1], b[2*k], g);
    end
  endtask

  task automatic frame_begin();
    spi_cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic frame_end();
    #(HALF);
    spi_cs_n = 1'b1;
    #(4*HALF);
  endtask

  task automatic check_cfg(input string req, input logic [7:0] exp);
    chk(req, 32'({nand_ce_n, nand_cle, nand_ale, fan_on, led_n}), 32'(exp));
  endtask

  initial begin
    #(150000 * CLK_PERIOD);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int         start;
    rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0; spi_mosi2 = 1'b0;
    nand_rdy = 1'b1;
    #(5*CLK_PERIOD);
    rst_n = 1'b1;
    #(5*CLK_PERIOD);

    // R1 reset state
    check_cfg("R1 reset config", 8'h8F);
    chk("R1 reset strobes", 32'({nand_we_n, nand_re_n, nand_dq_oe}), 32'b110);
    chk("R1 reset miso", 32'(spi_miso), 32'd0);

    // R2/R3 config byte mapping, MSB first
    frame_begin(); send_byte(8'h09, r); send_byte(8'h4A, r); frame_end();
    check_cfg("R2 R3 config 4A", 8'h4A);
    chk("R2 chip enable low", 32'(nand_ce_n), 32'd0);
    chk("R2 cle bit6", 32'(nand_cle), 32'd1);
    frame_begin(); send_byte(8'h09, r); send_byte(8'h35, r); send_byte(8'hFF, r); frame_end();
    check_cfg("R2 extra byte ignored", 8'h35);

    // R4 dual-line write with trailing byte
    frame_begin(); send_byte(8'h08, r);
    send_dual(8'hA5); send_dual(8'h3C); send_dual(8'h81); send_dual(8'h00);
    frame_end();
    chk("R4 write count", 32'(wr_log.size()), 32'd3);
    if (wr_log.size() == 3) begin
      chk("R4 byte0", 32'(wr_log[0]), 32'hA5);
      chk("R4 byte1", 32'(wr_log[1]), 32'h3C);
      chk("R4 byte2", 32'(wr_log[2]), 32'h81);
    end
    wr_log.delete();

    // R6 normal read, one dummy byte
    start = rd_idx;
    frame_begin(); send_byte(8'h0A, r);
    send_byte(8'h00, r);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'h00, r);
      chk("R6 read data", 32'(r), 32'(rd_pattern(start + k)));
    end
    frame_end();

    // R7 fast read, four dummy bytes
    start = rd_idx;
    frame_begin(); send_byte(8'h0B, r);
    send_byte(8'h00, r); send_byte(8'h00, r); send_byte(8'h00, r);
    chk("R7 no read before fourth dummy", 32'(rd_idx), 32'(start));
    send_byte(8'h00, r);
    for (int k = 0; k < 2; k++) begin
      send_byte(8'h00, r);
      chk("R7 fast read data", 32'(r), 32'(rd_pattern(start + k)));
    end
    frame_end();

    // R8 read held off while ready low
    start = rd_idx;
    nand_rdy = 1'b0;
    frame_begin(); send_byte(8'h0A, r); send_byte(8'h00, r);
    #(30*CLK_PERIOD);
    chk("R8 no read while busy", 32'(rd_idx), 32'(start));
    chk("R9 host sees busy", 32'(host_rdy), 32'd0);
    nand_rdy = 1'b1;
    #(10*CLK_PERIOD);
    send_byte(8'h00, r);
    chk("R8 read after ready", 32'(r), 32'(rd_pattern(start)));
    frame_end();

    // R10 abort partial byte
    frame_begin();
    for (int i = 0; i < 4; i++) begin
      logic g;
      spi_clock(1'b0, 1'b0, g);
    end
    frame_end();
    frame_begin(); send_byte(8'h09, r); send_byte(8'h8C, r); frame_end();
    check_cfg("R10 new frame after abort", 8'h8C);
    frame_begin(); send_byte(8'h08, r); send_dual(8'hA1);
    begin logic g; spi_clock(1'b1, 1'b1, g); spi_clock(1'b0, 1'b1, g); end
    frame_end();
    chk("R10 R4 aborted write drops byte", 32'(wr_log.size()), 32'd0);

    // R11 unknown opcode
    start = rd_idx;
    frame_begin(); send_byte(8'h3F, r); send_byte(8'h09, r); send_byte(8'h00, r);
    send_byte(8'h08, r); send_byte(8'h55, r); frame_end();
    check_cfg("R11 config unchanged", 8'h8C);
    chk("R11 no writes", 32'(wr_log.size()), 32'd0);
    chk("R11 no reads", 32'(rd_idx), 32'(start));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule